// File: doc/BRIEF.md
# Integer ALU with Adder, Logic Unit and Barrel Shifter

This block is the combinational execute-stage arithmetic unit of a small five-stage integer pipeline. Three independent sub-units work on the same two operands in parallel: an adder that also subtracts, a bitwise unit for AND, OR and XOR, and a barrel shifter. A result selector chooses one sub-unit's output. A zero flag is derived from the chosen result, and the adder's carry-out is brought out as well.

Operations are requested through separate strobes, not through an encoded opcode. With no strobe set the unit adds, which is the form used for load and store address generation. The zero flag lets branch-on-equal and branch-on-not-equal logic test the outcome of a subtraction. The shift distance is always taken from the low five bits of operand B. There are no registers and no reset: every output follows the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: With no strobe set, result equals (A + B) modulo 2^32 and carry_out equals bit 32 of the unsigned sum.
- R2: With only sub_en set, result equals (A - B) modulo 2^32, computed as A + ~B + 1, and carry_out is 1 exactly when A >= B as unsigned numbers.
- R3: With shift_en low, and_en selects A & B, otherwise or_en selects A | B, otherwise xor_en selects A ^ B. The priority is AND over OR over XOR, and any of the three overrides the adder.
- R4: With shift_en and shl_en set, result equals A shifted left by B[4:0] with zero fill. B[31:5] has no effect.
- R5: With shift_en set and both shl_en and sra_en low, result equals A shifted right logically by B[4:0], so the vacated upper bits are zero.
- R6: With shift_en and sra_en set and shl_en low, result equals A shifted right by B[4:0], and every vacated upper bit is a copy of A[31].
- R7: When shl_en is set, sra_en has no effect, and the shift is left logical.
- R8: shift_en overrides every logic strobe and sub_en in the choice of result.
- R9: zero is 1 exactly when the selected 32-bit result is all zeros, whichever sub-unit produced it.
- R10: carry_out always reflects the adder for the present A, B and sub_en, including when the logic unit or the shifter drives result.
- R11: A shift by 0 returns A unchanged in all three shift modes. A shift by 31 moves bit 0 to bit 31 (left), or bit 31 to bit 0 (right).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B; bits 4:0 also give the shift distance |
| sub_en | input | 1 | Adder subtracts B instead of adding it |
| and_en | input | 1 | Select bitwise AND |
| or_en | input | 1 | Select bitwise OR |
| xor_en | input | 1 | Select bitwise XOR |
| shift_en | input | 1 | Select the barrel shifter |
| shl_en | input | 1 | Shifter direction is left |
| sra_en | input | 1 | Right shifts replicate the sign bit |
| result | output | 32 | Selected sub-unit output |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Carry from bit 32 of the adder |

## Verification
The adder keeps running while the shifter or logic unit owns the result, so in a single cycle carry_out reports one sub-unit and result and zero report another. The bench provokes this overlap by asserting sub_en together with shift or logic strobes, in fixed vectors and in random ones. It judges result and zero against a priority model of the selected unit, and carry_out against a separate model of the adder alone. The vectors where strobes collide (shift with AND, left with signed, AND with OR) check that the lower-priority request leaves no trace in the result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int ALU_W = 32;

    typedef enum logic [1:0] {
        UNIT_ADD   = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2
    } unit_sel_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_AND  = 2'd1,
        BOP_OR   = 2'd2,
        BOP_XOR  = 2'd3
    } bit_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_mode_e;

    typedef struct packed {
        unit_sel_e   unit;
        bit_op_e     bop;
        shift_mode_e smode;
        logic        sub;
    } alu_ctrl_t;

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int W = 32
) (
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] b_eff_d;
    logic [W:0]   sum_ext_d;

    always_comb begin
        b_eff_d   = sub_i ? ~b_i : b_i;
        sum_ext_d = {1'b0, a_i} + {1'b0, b_eff_d} + {{W{1'b0}}, sub_i};
        sum_o     = sum_ext_d[W-1:0];
        carry_o   = sum_ext_d[W];
    end

    always_comb begin
        // R2
        sub_self_zero_chk: assert (!(sub_i && (a_i == b_i)) ||
                                   (sum_o == '0 && carry_o))
            else $error("subtracting equal operands must give zero with carry");
        // R1
        add_identity_chk: assert (sub_i || (b_i != '0) ||
                                  (sum_o == a_i && !carry_o))
            else $error("adding zero must return A without carry");
    end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  bit_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            BOP_AND: y_o = a_i & b_i;
            BOP_OR:  y_o = a_i | b_i;
            BOP_XOR: y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end

    always_comb begin
        // R3
        and_subset_chk: assert (op_i != BOP_AND || ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0))
            else $error("AND output has a bit absent from an operand");
        // R3
        or_superset_chk: assert (op_i != BOP_OR || ((y_o & a_i) == a_i && (y_o & b_i) == b_i))
            else $error("OR output dropped an operand bit");
        // R3
        xor_equal_chk: assert (op_i != BOP_XOR || a_i != b_i || y_o == '0)
            else $error("XOR of equal operands is not zero");
    end
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  shift_mode_e        mode_i,
    input  logic [W-1:0]       a_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]       y_o
);
    localparam int SHW = $clog2(W);

    logic         left_d;
    logic         fill_d;
    logic [W-1:0] in_rev_d;
    logic [W-1:0] stage_d [0:SHW];
    logic [W-1:0] out_rev_d;

    always_comb begin
        left_d = (mode_i == SH_LEFT);
        fill_d = (mode_i == SH_RARI) && a_i[W-1];
    end

    // Left shifts reuse the right-shift network on bit-reversed data.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign in_rev_d[i]  = a_i[W-1-i];
        assign out_rev_d[i] = stage_d[SHW][W-1-i];
    end

    assign stage_d[0] = left_d ? in_rev_d : a_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stage_d[s+1] = amt_i[s] ? {{DIST{fill_d}}, stage_d[s][W-1:DIST]}
                                       : stage_d[s];
    end

    assign y_o = left_d ? out_rev_d : stage_d[SHW];

    always_comb begin
        // R11
        zero_dist_chk: assert (amt_i != '0 || y_o == a_i)
            else $error("shift by zero altered the operand");
        // R5
        rlog_top_chk: assert (mode_i != SH_RLOG || amt_i == '0 || !y_o[W-1])
            else $error("logical right shift left a set top bit");
        // R6
        rari_sign_chk: assert (mode_i != SH_RARI || y_o[W-1] == a_i[W-1])
            else $error("arithmetic right shift lost the sign");
        // R4
        left_low_chk: assert (mode_i != SH_LEFT || amt_i == '0 || !y_o[0])
            else $error("left shift left a set bit 0");
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub_en,
    input  logic         and_en,
    input  logic         or_en,
    input  logic         xor_en,
    input  logic         shift_en,
    input  logic         shl_en,
    input  logic         sra_en,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         carry_out
);
    localparam int SHW = $clog2(W);

    alu_ctrl_t    ctrl_d;
    logic [W-1:0] add_y_d;
    logic [W-1:0] log_y_d;
    logic [W-1:0] sh_y_d;
    logic         add_c_d;

    // Strobe decode: shifter over logic unit over adder.
    always_comb begin
        ctrl_d     = '0;
        ctrl_d.sub = sub_en;
        if (and_en)      ctrl_d.bop = BOP_AND;
        else if (or_en)  ctrl_d.bop = BOP_OR;
        else if (xor_en) ctrl_d.bop = BOP_XOR;
        else             ctrl_d.bop = BOP_NONE;
        if (shl_en)      ctrl_d.smode = SH_LEFT;
        else if (sra_en) ctrl_d.smode = SH_RARI;
        else             ctrl_d.smode = SH_RLOG;
        if (shift_en)                  ctrl_d.unit = UNIT_SHIFT;
        else if (ctrl_d.bop != BOP_NONE) ctrl_d.unit = UNIT_LOGIC;
        else                           ctrl_d.unit = UNIT_ADD;
    end

    int_alu_adder #(.W(W)) i_adder (
        .sub_i   (ctrl_d.sub),
        .a_i     (opa),
        .b_i     (opb),
        .sum_o   (add_y_d),
        .carry_o (add_c_d)
    );

    int_alu_logic #(.W(W)) i_logic (
        .op_i (ctrl_d.bop),
        .a_i  (opa),
        .b_i  (opb),
        .y_o  (log_y_d)
    );

    int_alu_shifter #(.W(W)) i_shifter (
        .mode_i (ctrl_d.smode),
        .a_i    (opa),
        .amt_i  (opb[SHW-1:0]),
        .y_o    (sh_y_d)
    );

    always_comb begin
        unique case (ctrl_d.unit)
            UNIT_LOGIC: result = log_y_d;
            UNIT_SHIFT: result = sh_y_d;
            default:    result = add_y_d;
        endcase
        zero      = ~|result;
        carry_out = add_c_d;
    end

    always_comb begin
        // R9
        sub_zero_eq_chk: assert (!(sub_en && !shift_en && !and_en && !or_en && !xor_en && zero)
                                 || opa == opb)
            else $error("zero after subtract with unequal operands");
        // R10
        sub_carry_order_chk: assert (!(sub_en && opa < opb) || !carry_out)
            else $error("carry set on subtract with A below B");
    end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
    localparam int  W        = 32;
    localparam time CLK_HALF = 5ns;
    localparam int  N_VEC    = 14;
    localparam int  N_RAND   = 600;

    // ctrl bits: [6]=sub [5]=and [4]=or [3]=xor [2]=shift [1]=shl [0]=sra
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [6:0]   ctrl;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t VECS [0:N_VEC-1] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 7'b0000000, 32'h0000_0000}, // R1 wrap to zero
        '{32'h0000_0005, 32'h0000_0005, 7'b1000000, 32'h0000_0000}, // R2 equal
        '{32'h0000_0003, 32'h0000_0005, 7'b1000000, 32'hFFFF_FFFE}, // R2 borrow
        '{32'hF0F0_F0F0, 32'hFF00_FF00, 7'b0100000, 32'hF000_F000}, // R3 and
        '{32'hF0F0_F0F0, 32'hFF00_FF00, 7'b0010000, 32'hFFF0_FFF0}, // R3 or
        '{32'hF0F0_F0F0, 32'hFF00_FF00, 7'b0001000, 32'h0FF0_0FF0}, // R3 xor
        '{32'h0000_0001, 32'h0000_001F, 7'b0000110, 32'h8000_0000}, // R4 R11 31
        '{32'h8000_0000, 32'h0000_001F, 7'b0000100, 32'h0000_0001}, // R5 R11 31
        '{32'h8000_0000, 32'h0000_001F, 7'b0000101, 32'hFFFF_FFFF}, // R6
        '{32'h8000_0000, 32'h0000_0020, 7'b0000101, 32'h8000_0000}, // R11 upper B ignored
        '{32'h8000_0001, 32'h0000_0001, 7'b0000111, 32'h0000_0002}, // R7
        '{32'h0000_00F0, 32'h0000_0004, 7'b1100100, 32'h0000_000F}, // R8
        '{32'h0000_000C, 32'h0000_000A, 7'b0110000, 32'h0000_0008}, // R3 priority
        '{32'h7FFF_FFFF, 32'h0000_0004, 7'b0000101, 32'h07FF_FFFF}  // R6 positive
    };

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic         sub_en, and_en, or_en, xor_en, shift_en, shl_en, sra_en;
    logic [W-1:0] result;
    logic         zero, carry_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    int_alu #(.W(W)) i_int_alu (
        .opa(opa), .opb(opb), .sub_en(sub_en), .and_en(and_en), .or_en(or_en),
        .xor_en(xor_en), .shift_en(shift_en), .shl_en(shl_en), .sra_en(sra_en),
        .result(result), .zero(zero), .carry_out(carry_out)
    );

    function automatic logic [W-1:0] ref_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic [6:0] c);
        int unsigned amt = b[4:0];
        if (c[2]) begin
            if (c[1])      return a << amt;
            else if (c[0]) return W'($signed(a) >>> amt);
            else           return a >> amt;
        end
        if (c[5]) return a & b;
        if (c[4]) return a | b;
        if (c[3]) return a ^ b;
        if (c[6]) return a - b;
        return a + b;
    endfunction

    function automatic logic ref_carry(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic sub);
        if (sub) return (a >= b);
        return ((W+1)'(a) + (W+1)'(b)) > (W+1)'({W{1'b1}});
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [6:0] c);
        @(posedge clk);
        opa = a; opb = b;
        {sub_en, and_en, or_en, xor_en, shift_en, shl_en, sra_en} = c;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [6:0] c, input logic [W-1:0] exp);
        check(req, result, exp);
        check("R9 zero", W'(zero), W'(exp == '0));
        check("R10 carry", W'(carry_out), W'(ref_carry(a, b, c[6])));
    endtask

    initial begin
        opa = '0; opb = '0;
        {sub_en, and_en, or_en, xor_en, shift_en, shl_en, sra_en} = '0;
        @(negedge clk);
        // Idle state with all inputs low: R1 R9 R10
        check("R1 idle result", result, '0);
        check("R9 idle zero", W'(zero), W'(1));
        check("R10 idle carry", W'(carry_out), '0);

        for (int i = 0; i < N_VEC; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].ctrl);
            check_all($sformatf("vector %0d", i), VECS[i].a, VECS[i].b, VECS[i].ctrl, VECS[i].exp);
        end

        // R10: carry reported while shifter owns result (sub with shift)
        apply(32'h0000_0010, 32'h0000_0002, 7'b1000100);
        check("R8 shift over sub", result, 32'h0000_0004);
        check("R10 carry under shift", W'(carry_out), W'(1));

        // R11: shift by zero in each mode
        for (int m = 0; m < 3; m++) begin
            logic [6:0] c = (m == 0) ? 7'b0000110 : (m == 1) ? 7'b0000100 : 7'b0000101;
            apply(32'hA5C3_0F81, 32'hFFFF_FFE0, c);
            check("R11 zero distance", result, 32'hA5C3_0F81);
        end

        // Random operands and strobes against the reference model
        for (int i = 0; i < N_RAND; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] b = $urandom;
            logic [6:0]   c = 7'($urandom);
            if (i % 5 == 0) b[4:0] = 5'd0;
            if (i % 5 == 1) b[4:0] = 5'd31;
            if (i % 7 == 0) b = a;
            apply(a, b, c);
            check_all("R1-model random", a, b, c, ref_result(a, b, c));
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule